// File: doc/BRIEF.md
# Accumulator Machine Control Sequencer

This block steps an 8-bit accumulator machine through fetch, decode and execute. It holds the program counter, the instruction register and the state machine. Instructions and data share one small word-addressed memory, so one address bus serves both kinds of access. The block reads the memory through that bus, writes to it for stores, and steers an outside arithmetic datapath with two select codes. One code drives the B-register input and the other drives the ALU and accumulator update. The datapath returns only the accumulator's sign bit.

Opcodes come in two formats. When the high nibble is 0001, the instruction is one byte long. Any other defined opcode is followed by a second byte, and the low address bits of that byte name the operand. Memory-reading arithmetic uses high nibble 1000 and picks its operation with the low nibble. The memory is assumed to read combinationally: the word at `mem_addr` appears on `mem_rdata` in the same cycle. A store is taken by the memory at the clock edge that ends a cycle with `mem_wr` high.

Top module: `acc_seq_ctrl`

## Requirements
- R1: While reset is low, and right after it is released, the block fetches from address 0 (`mem_addr`=0, `mem_rd`=1). In the same state `mem_wr`=0, `halted`=0, `b_sel`=0 and `alu_op`=0.
- R2: A fetch takes one cycle and the PC advances one word for every instruction byte consumed. Cycle counts per instruction are: CLR, INC, HALT and unknown codes 2; DEC 3; JMP, JMPN and STORE 4; ADD and LOAD 5; SUB 6.
- R3: The decode cycle of CLR (0x10) drives `alu_op`=1 (zero) and INC (0x14) drives `alu_op`=2 (add one). DEC (0x15) drives `b_sel`=3 (all ones) and then `alu_op`=3 (A+B). After any accumulator update the next cycle is a fetch.
- R4: For ADD (0x86) and LOAD (0x82), the operand address is the low 6 bits of the second byte; its upper bits are ignored. The block reads that address with `b_sel`=1 (load from memory), then drives `alu_op`=3 for ADD or `alu_op`=5 (pass B) for LOAD.
- R5: SUB (0x87) loads B from memory, then drives `b_sel`=2 (complement B), then `alu_op`=4 (A+B+1).
- R6: STORE (0x41) drives `mem_wr` for exactly one cycle, with `mem_addr` set to the operand address.
- R7: JMP (0x27) makes the next fetch come from the operand address.
- R8: JMPN (0x23) jumps only when `acc_neg` is high. Otherwise execution continues at the byte after the address byte.
- R9: HALT (0x11) raises `halted` and keeps it high until reset. While halted there are no memory reads or writes and no datapath activity.
- R10: A byte that is not a defined opcode is a one-byte no-op. It changes neither the accumulator nor B.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rdata | input | 8 | Memory word at `mem_addr`, same cycle |
| acc_neg | input | 1 | Sign bit of the accumulator |
| mem_addr | output | 6 | Shared instruction and data address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe (memory stores the accumulator) |
| b_sel | output | 2 | B-register input: 0 hold, 1 memory, 2 complement, 3 all ones |
| alu_op | output | 3 | Accumulator update: 0 hold, 1 zero, 2 add one, 3 A+B, 4 A+B+1, 5 pass B |
| halted | output | 1 | High while the machine is stopped |

## Verification
Two jobs fall in the same cycle. When an instruction's last step ends, the datapath updates the accumulator at the same edge where the sequencer returns to fetch. The branch test then reads `acc_neg` as left by the instruction just before it. A countdown loop provokes this: DEC is followed at once by JMPN, so the branch sees the freshly decremented accumulator. The run is judged by the total cycle count and the final accumulator, which show whether the branch was taken in the right iteration. A cycle-level check and an assertion also guard that read and write strobes never overlap.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

   localparam int DATA_W = 8;

   // instruction class in the high nibble
   localparam logic [3:0] CLS_SHORT = 4'h1;

   localparam logic [DATA_W-1:0] OPC_CLR   = 8'h10;
   localparam logic [DATA_W-1:0] OPC_HALT  = 8'h11;
   localparam logic [DATA_W-1:0] OPC_INC   = 8'h14;
   localparam logic [DATA_W-1:0] OPC_DEC   = 8'h15;
   localparam logic [DATA_W-1:0] OPC_STORE = 8'h41;
   localparam logic [DATA_W-1:0] OPC_JMPN  = 8'h23;
   localparam logic [DATA_W-1:0] OPC_JMP   = 8'h27;
   localparam logic [DATA_W-1:0] OPC_ADD   = 8'h86;
   localparam logic [DATA_W-1:0] OPC_SUB   = 8'h87;
   localparam logic [DATA_W-1:0] OPC_LOAD  = 8'h82;

   typedef enum logic [1:0] {
      BS_HOLD = 2'd0, BS_MEM = 2'd1, BS_INV = 2'd2, BS_ONES = 2'd3
   } bsel_e;

   typedef enum logic [2:0] {
      AL_HOLD = 3'd0, AL_ZERO = 3'd1, AL_INC = 3'd2,
      AL_ADD = 3'd3, AL_ADD1 = 3'd4, AL_PASSB = 3'd5
   } alu_e;

   typedef enum logic [1:0] {
      PC_HOLD = 2'd0, PC_INC = 2'd1, PC_LOAD = 2'd2
   } pcop_e;

   typedef enum logic [3:0] {
      S_FETCH, S_DECODE, S_OPND, S_JUMP, S_WRITE,
      S_MEMRD, S_NEGB, S_EXEC, S_HALT
   } state_e;

   typedef enum logic [2:0] {
      OP_NONE, OP_DEC, OP_STORE, OP_JMP, OP_JMPN, OP_ADD, OP_SUB, OP_LOAD
   } op_e;

endpackage

// File: rtl/acc_seq_pc.sv
module acc_seq_pc
   import acc_seq_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter logic [ADDR_W-1:0] START_PC = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  pcop_e             pc_op,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] pc
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc <= START_PC;
      end else begin
         case (pc_op)
            PC_INC:  pc <= pc + 1'b1;
            PC_LOAD: pc <= target;
            default: pc <= pc;
         endcase
      end
   end

endmodule

// File: rtl/acc_seq_ir.sv
module acc_seq_ir
   import acc_seq_pkg::*;
#(
   parameter int ADDR_W = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ir_load,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] ir,
   output logic [ADDR_W-1:0] target
);

   always_ff @(posedge clk) begin
      if (!rst_n)       ir <= '0;
      else if (ir_load) ir <= rdata;
   end

   generate
      if (ADDR_W == DATA_W) begin : g_full
         assign target = ir;
      end else begin : g_slice
         assign target = ir[ADDR_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/acc_seq_fsm.sv
module acc_seq_fsm
   import acc_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ir,
   input  logic              acc_neg,
   output pcop_e             pc_op,
   output logic              ir_load,
   output logic              use_tgt,
   output logic              mem_rd,
   output logic              mem_wr,
   output bsel_e             b_sel,
   output alu_e              alu_op,
   output logic              halted
);

   state_e state, nxt;
   op_e    op_q, op_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_FETCH;
         op_q  <= OP_NONE;
      end else begin
         state <= nxt;
         op_q  <= op_d;
      end
   end

   always_comb begin
      nxt     = state;
      op_d    = op_q;
      pc_op   = PC_HOLD;
      ir_load = 1'b0;
      use_tgt = 1'b0;
      mem_rd  = 1'b0;
      mem_wr  = 1'b0;
      b_sel   = BS_HOLD;
      alu_op  = AL_HOLD;
      case (state)
         S_FETCH: begin
            mem_rd  = 1'b1;
            ir_load = 1'b1;
            pc_op   = PC_INC;
            nxt     = S_DECODE;
         end
         S_DECODE: begin
            nxt  = S_FETCH;
            op_d = OP_NONE;
            if (ir[7:4] == CLS_SHORT) begin
               case (ir)
                  OPC_CLR:  alu_op = AL_ZERO;
                  OPC_INC:  alu_op = AL_INC;
                  OPC_DEC: begin
                     b_sel = BS_ONES;
                     op_d  = OP_DEC;
                     nxt   = S_EXEC;
                  end
                  OPC_HALT: nxt = S_HALT;
                  default:  nxt = S_FETCH;
               endcase
            end else begin
               nxt = S_OPND;
               case (ir)
                  OPC_STORE: op_d = OP_STORE;
                  OPC_JMP:   op_d = OP_JMP;
                  OPC_JMPN:  op_d = OP_JMPN;
                  OPC_ADD:   op_d = OP_ADD;
                  OPC_SUB:   op_d = OP_SUB;
                  OPC_LOAD:  op_d = OP_LOAD;
                  default:   nxt  = S_FETCH;
               endcase
            end
         end
         S_OPND: begin
            mem_rd  = 1'b1;
            ir_load = 1'b1;
            pc_op   = PC_INC;
            case (op_q)
               OP_JMP, OP_JMPN: nxt = S_JUMP;
               OP_STORE:        nxt = S_WRITE;
               default:         nxt = S_MEMRD;
            endcase
         end
         S_JUMP: begin
            if (op_q == OP_JMP || acc_neg) pc_op = PC_LOAD;
            nxt = S_FETCH;
         end
         S_WRITE: begin
            use_tgt = 1'b1;
            mem_wr  = 1'b1;
            nxt     = S_FETCH;
         end
         S_MEMRD: begin
            use_tgt = 1'b1;
            mem_rd  = 1'b1;
            b_sel   = BS_MEM;
            nxt     = (op_q == OP_SUB) ? S_NEGB : S_EXEC;
         end
         S_NEGB: begin
            b_sel = BS_INV;
            nxt   = S_EXEC;
         end
         S_EXEC: begin
            case (op_q)
               OP_SUB:  alu_op = AL_ADD1;
               OP_LOAD: alu_op = AL_PASSB;
               default: alu_op = AL_ADD;
            endcase
            nxt = S_FETCH;
         end
         S_HALT:  nxt = S_HALT;
         default: nxt = S_FETCH;
      endcase
   end

   assign halted = (state == S_HALT);

   // R11: strobes are exclusive
   assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R9: halt is sticky and quiet
   assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && !mem_rd && !mem_wr && alu_op == AL_HOLD));

   // R6: a store strobe lasts one cycle
   assert_store_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr);

   // R3: an accumulator update is followed by a fetch
   assert_acc_then_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_op != AL_HOLD) |=> (mem_rd && ir_load && !use_tgt));

   // R5: complementing B leads into add-with-carry
   assert_sub_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (b_sel == BS_INV) |=> (alu_op == AL_ADD1));

endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
   import acc_seq_pkg::*;
#(
   parameter int MEM_WORDS = 64,
   localparam int ADDR_W   = $clog2(MEM_WORDS)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        mem_rdata,
   input  logic              acc_neg,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [1:0]        b_sel,
   output logic [2:0]        alu_op,
   output logic              halted
);

   generate
      if (MEM_WORDS < 4 || (MEM_WORDS & (MEM_WORDS - 1)) != 0 || ADDR_W > DATA_W)
      begin : g_bad_param
         initial $fatal(1, "MEM_WORDS must be a power of two that an operand byte can address");
      end
   endgenerate

   pcop_e             pc_op;
   logic              ir_load, use_tgt;
   logic [DATA_W-1:0] ir;
   logic [ADDR_W-1:0] pc, target;
   bsel_e             b_sel_w;
   alu_e              alu_op_w;

   acc_seq_pc #(.ADDR_W(ADDR_W)) u_pc (
      .clk(clk), .rst_n(rst_n), .pc_op(pc_op), .target(target), .pc(pc)
   );

   acc_seq_ir #(.ADDR_W(ADDR_W)) u_ir (
      .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .rdata(mem_rdata),
      .ir(ir), .target(target)
   );

   acc_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .ir(ir), .acc_neg(acc_neg),
      .pc_op(pc_op), .ir_load(ir_load), .use_tgt(use_tgt),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .b_sel(b_sel_w),
      .alu_op(alu_op_w), .halted(halted)
   );

   assign mem_addr = use_tgt ? target : pc;
   assign b_sel    = b_sel_w;
   assign alu_op   = alu_op_w;

   // R6: a store always addresses the operand, never the PC
   assert_store_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (mem_addr == target));

endmodule

// File: tb/sim_acc_seq_ctrl.sv
module sim_acc_seq_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 12;
   // {opcode, operand, acc start, expected acc, expected word 0x20, expected cycles}
   localparam logic [47:0] VEC [0:NV-1] = '{
      48'h10_00_5A_00_25_04, 48'h14_00_7F_80_25_04, 48'h15_00_00_FF_25_05,
      48'h86_20_10_35_25_07, 48'h87_20_10_EB_25_08, 48'h82_20_10_25_25_07,
      48'h82_E0_10_25_25_07, 48'h27_30_05_05_25_06, 48'h23_30_85_85_25_06,
      48'h23_30_05_00_25_08, 48'h99_00_3C_3C_25_04, 48'h41_20_66_66_66_06
   };

   logic       clk = 0;
   logic       rst_n = 0;
   logic [5:0] mem_addr;
   logic       mem_rd, mem_wr, halted;
   logic [1:0] b_sel;
   logic [2:0] alu_op;
   logic [7:0] mem [64];
   logic [7:0] acc = 0, breg = 0;
   logic [7:0] mem_rdata;
   int checks = 0, fails = 0, wr_cnt = 0, overlap = 0, ticks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign mem_rdata = mem[mem_addr];

   acc_seq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .acc_neg(acc[7]),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .b_sel(b_sel), .alu_op(alu_op), .halted(halted)
   );

   // behavioural datapath and memory
   always @(posedge clk) begin
      ticks <= ticks + 1;
      if (rst_n) begin
         if (mem_wr) begin
            mem[mem_addr] <= acc;
            wr_cnt <= wr_cnt + 1;
         end
         if (mem_rd && mem_wr) overlap <= overlap + 1;
         case (b_sel)
            2'd1: breg <= mem_rdata;
            2'd2: breg <= ~breg;
            2'd3: breg <= 8'hFF;
            default: breg <= breg;
         endcase
         case (alu_op)
            3'd1: acc <= 8'h00;
            3'd2: acc <= acc + 8'd1;
            3'd3: acc <= acc + breg;
            3'd4: acc <= acc + breg + 8'd1;
            3'd5: acc <= breg;
            default: acc <= acc;
         endcase
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (ticks > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", ticks, 150000);
            finish_run();
         end
      end
   end

   function automatic string vec_req(input int i);
      case (i)
         0, 1, 2: return "R3";
         3, 5, 6: return "R4";
         4:       return "R5";
         7:       return "R7";
         8, 9:    return "R8";
         10:      return "R10";
         default: return "R6";
      endcase
   endfunction

   task automatic clear_mem();
      for (int a = 0; a < 64; a++) mem[a] = 8'h00;
   endtask

   // release reset and count edges until halted shows
   task automatic run_to_halt(output int cyc);
      @(negedge clk);
      rst_n = 1;
      cyc = 0;
      do begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end while (!halted && cyc < 200);
   endtask

   initial begin
      int cyc;
      logic [7:0] op, opnd;
      bit two, jmp;
      // R1: state held in reset
      clear_mem();
      repeat (2) @(negedge clk);
      chk(mem_addr == 0 && mem_rd && !mem_wr, "R1 reset fetch", {mem_addr, mem_rd, mem_wr}, 32'h2);
      chk(!halted && b_sel == 0 && alu_op == 0, "R1 reset idle", {halted, b_sel, alu_op}, 0);

      for (int i = 0; i < NV; i++) begin
         rst_n = 0;
         @(negedge clk);
         op   = VEC[i][47:40];
         opnd = VEC[i][39:32];
         two  = (op == 8'h41 || op == 8'h23 || op == 8'h27 ||
                 op == 8'h86 || op == 8'h87 || op == 8'h82);
         jmp  = (op == 8'h23 || op == 8'h27);
         clear_mem();
         mem[0]    = op;
         mem[8'h20] = 8'h25;
         mem[8'h30] = 8'h11;
         if (!two) mem[1] = 8'h11;
         else begin
            mem[1] = opnd;
            if (jmp) begin mem[2] = 8'h10; mem[3] = 8'h11; end
            else mem[2] = 8'h11;
         end
         acc = VEC[i][31:24];
         breg = 8'h5C;
         wr_cnt = 0;
         run_to_halt(cyc);
         chk(acc == VEC[i][23:16], vec_req(i), acc, VEC[i][23:16]);
         chk(mem[8'h20] == VEC[i][15:8], vec_req(i), mem[8'h20], VEC[i][15:8]);
         chk(cyc == int'(VEC[i][7:0]), {"R2 cycles ", vec_req(i)}, cyc, VEC[i][7:0]);
         chk(wr_cnt == (op == 8'h41 ? 1 : 0), "R6 write count", wr_cnt, (op == 8'h41 ? 1 : 0));
         if (op == 8'h99)
            chk(breg == 8'h5C, "R10 breg untouched", breg, 8'h5C);
      end

      // R9: halt persists, no activity
      begin
         logic [7:0] acc_h;
         acc_h = acc;
         repeat (10) @(negedge clk);
         chk(halted && !mem_rd && !mem_wr, "R9 halted quiet", {halted, mem_rd, mem_wr}, 32'h4);
         chk(acc == acc_h && alu_op == 0, "R9 acc frozen", acc, acc_h);
      end

      // R8 R7: countdown loop, DEC then JMPN back to back
      rst_n = 0;
      @(negedge clk);
      clear_mem();
      mem[0] = 8'h82; mem[1] = 8'h20; mem[2] = 8'h15;
      mem[3] = 8'h23; mem[4] = 8'h07; mem[5] = 8'h27; mem[6] = 8'h02;
      mem[7] = 8'h11; mem[8'h20] = 8'h03;
      acc = 0;
      run_to_halt(cyc);
      chk(acc == 8'hFF, "R8 loop exit value", acc, 8'hFF);
      chk(cyc == 47, "R7 R8 loop cycles", cyc, 47);

      // R1: reset from halt returns to fetch at 0
      rst_n = 0;
      @(negedge clk);
      @(negedge clk);
      chk(!halted && mem_addr == 0 && mem_rd, "R1 reset from halt", {halted, mem_addr, mem_rd}, 32'h1);

      // R11: no overlapping strobes over the whole run
      chk(overlap == 0, "R11 strobe overlap", overlap, 0);

      finish_run();
   end

endmodule